// File: doc/BRIEF.md
# Handshake Strobe Conditioner

This block conditions one handshake strobe line, either request or acknowledge, as it crosses a bus repeater from the receiving side to the driving side. It is a synchronous pipeline clocked by a fast sample clock. Its input is the sampled, active-high strobe, a flag that marks the strobe as a data clock, and a flag that says the line is currently driven from this side. Its outputs are the pull-down enable, the pull-up enable and the pull-up tri-state control for the pad logic on the opposite side.

The block has four stages. First, a leading-edge stage adds a programmable setup delay, but only for data clocks. Second, a trailing-edge stage ends the pulse on the first low sample and locks out bounce. Third, a recovery timer runs in parallel and keeps the line released for a minimum time after each deassertion. Last, a drive stage turns the filtered level into pad controls, with a short active pull-up pulse on release.

All delays are parameters in sample-clock cycles: `LEAD_CYC`, `LOCK_CYC`, `REC_CYC` and `PU_PULSE`, with defaults 4, 3, 6 and 2. In the requirements, GUARD means max(`LOCK_CYC`, `REC_CYC`).

Top module: `strobe_conditioner`

## Requirements
- R1: With `is_dclk` low, `pull_dn` rises on the third rising edge counted from the first edge that samples `strb_in` high, so the pulse passes with no added delay.
- R2: With `is_dclk` high, that rise comes `LEAD_CYC` edges later. An input pulse seen high on `LEAD_CYC` or fewer edges produces no output.
- R3: Deassertion is never delayed. In both modes, `pull_dn` falls on the third edge counted from the first low sample. The output width therefore equals the input width, less `LEAD_CYC` for a data clock.
- R4: The filtered strobe drops on the very first low sample of the input. If the input reasserts (bounces) right after that, the line is not asserted again until the guard has ended.
- R5: After a release, `pull_dn` stays low for exactly GUARD+1 cycles when the input reasserts at once and stays high. An assertion that is gone before the guard ends is never forwarded.
- R6: Pad control encoding:
  - while asserted: `pull_dn`=1, `pull_up`=0, `pull_up_hiz`=1;
  - on release, for `PU_PULSE` cycles: `pull_dn`=0, `pull_up`=1, `pull_up_hiz`=0;
  - afterwards: all outputs released, that is `pull_dn`=0, `pull_up`=0, `pull_up_hiz`=1.
- R7: While `self_drive` is high, the input is treated as deasserted. Raising `self_drive` during an assertion releases the line like a falling input.
- R8: After reset, `pull_dn`=0, `pull_up`=0 and `pull_up_hiz`=1, and the guard has already expired. An input raised right after reset passes with R1 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_in | input | 1 | Sampled strobe from the receiving side, active high |
| is_dclk | input | 1 | High when the strobe currently clocks data |
| self_drive | input | 1 | High when this side drives the line; blocks the input |
| pull_dn | output | 1 | Pull-down enable to the opposite pad |
| pull_up | output | 1 | Active pull-up enable to the opposite pad |
| pull_up_hiz | output | 1 | Pull-up tri-state control, 1 = pull-up released |

## Verification
Every input change is made on a falling clock edge. The bench then counts falling edges until a result is due:
- Counting from a change of `strb_in`, a normal assertion or any release shows on `pull_dn` at the third falling edge, and a data-clock assertion shows `LEAD_CYC` edges later.
- The pull-up pulse covers the third and fourth falling edges after a release. The output is back in its released state at the fifth.

Each check samples one edge before and one edge at the due point, so a result that comes one cycle early or late is caught. Pulse widths and guard gaps are measured by counting high or low samples over a window that is longer than the longest expected response.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sc_lead_stage.sv
module sc_lead_stage #(
  parameter int LEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_in,
  input  logic is_dclk,
  input  logic self_drive,
  output logic lead_out
);
  localparam int CW = $clog2(LEAD_CYC + 1);

  logic          gated;
  logic [CW-1:0] cnt;

  assign gated = strb_in & ~self_drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_out <= 1'b0;
      cnt      <= '0;
    end else if (!gated) begin
      lead_out <= 1'b0;
      cnt      <= '0;
    end else if (!lead_out) begin
      if (!is_dclk || cnt == CW'(LEAD_CYC)) lead_out <= 1'b1;
      else                                  cnt      <= cnt + 1'b1;
    end
  end

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (gated && !is_dclk) |=> lead_out);
  assert_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (!strb_in) |=> !lead_out);
  assert_local_block_R7: assert property (@(posedge clk) disable iff (rst)
    self_drive |=> !lead_out);
endmodule

// File: rtl/sc_trail_stage.sv
module sc_trail_stage #(
  parameter int LOCK_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lead_in,
  input  logic hold,
  output logic line,
  output logic fall_now
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] lock;

  assign fall_now = line & ~lead_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= 1'b0;
      lock <= '0;
    end else if (fall_now) begin
      line <= 1'b0;
      lock <= LW'(LOCK_CYC);
    end else begin
      if (lock != '0) lock <= lock - 1'b1;
      if (!line && lead_in && lock == '0 && !hold) line <= 1'b1;
    end
  end

  assert_first_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (line && !lead_in) |=> !line);
  assert_guard_block_R5: assert property (@(posedge clk) disable iff (rst)
    (hold && !line) |=> !line);
endmodule

// File: rtl/sc_recovery_timer.sv
module sc_recovery_timer #(
  parameter int REC_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_now,
  output logic hold
);
  localparam int RW = $clog2(REC_CYC + 1);

  logic [RW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst)                 rcnt <= '0;
    else if (fall_now)       rcnt <= RW'(REC_CYC);
    else if (rcnt != '0)     rcnt <= rcnt - 1'b1;
  end

  assign hold = (rcnt != '0);

  assert_guard_load_R5: assert property (@(posedge clk) disable iff (rst)
    fall_now |=> hold);
  assert_reset_expired_R8: assert property (@(posedge clk)
    rst |=> !hold);
endmodule

// File: rtl/sc_pad_drive.sv
module sc_pad_drive #(
  parameter int PU_PULSE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic pull_dn,
  output logic pull_up,
  output logic pull_up_hiz
);
  localparam int PW = $clog2(PU_PULSE + 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_dn     <= 1'b0;
      pull_up     <= 1'b0;
      pull_up_hiz <= 1'b1;
      pcnt        <= '0;
    end else if (line) begin
      pull_dn     <= 1'b1;
      pull_up     <= 1'b0;
      pull_up_hiz <= 1'b1;
      pcnt        <= '0;
    end else if (pull_dn) begin
      pull_dn     <= 1'b0;
      pull_up     <= 1'b1;
      pull_up_hiz <= 1'b0;
      pcnt        <= PW'(PU_PULSE - 1);
    end else if (pull_up) begin
      if (pcnt == '0) begin
        pull_up     <= 1'b0;
        pull_up_hiz <= 1'b1;
      end else begin
        pcnt <= pcnt - 1'b1;
      end
    end
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(pull_dn && pull_up));
  assert_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    pull_up |-> !pull_up_hiz);
  assert_follow_R6: assert property (@(posedge clk) disable iff (rst)
    line |=> pull_dn);
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_dn) |-> pull_up);
endmodule

// File: rtl/strobe_conditioner.sv
module strobe_conditioner #(
  parameter int LEAD_CYC = 4,
  parameter int LOCK_CYC = 3,
  parameter int REC_CYC  = 6,
  parameter int PU_PULSE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_in,
  input  logic is_dclk,
  input  logic self_drive,
  output logic pull_dn,
  output logic pull_up,
  output logic pull_up_hiz
);
  import strobe_pkg::*;

  localparam int GUARD = max_int(LOCK_CYC, REC_CYC);

  logic lead_q;
  logic line;
  logic fall_now;
  logic hold;

  sc_lead_stage #(.LEAD_CYC(LEAD_CYC)) u_lead (
    .clk(clk), .rst(rst), .strb_in(strb_in), .is_dclk(is_dclk),
    .self_drive(self_drive), .lead_out(lead_q)
  );

  sc_trail_stage #(.LOCK_CYC(LOCK_CYC)) u_trail (
    .clk(clk), .rst(rst), .lead_in(lead_q), .hold(hold),
    .line(line), .fall_now(fall_now)
  );

  sc_recovery_timer #(.REC_CYC(REC_CYC)) u_rec (
    .clk(clk), .rst(rst), .fall_now(fall_now), .hold(hold)
  );

  sc_pad_drive #(.PU_PULSE(PU_PULSE)) u_pad (
    .clk(clk), .rst(rst), .line(line),
    .pull_dn(pull_dn), .pull_up(pull_up), .pull_up_hiz(pull_up_hiz)
  );

  initial begin
    assert_params_R5: assert (GUARD >= 1 && LEAD_CYC >= 1 && PU_PULSE >= 1);
  end
endmodule

// File: tb/sim_strobe_conditioner.sv
module sim_strobe_conditioner;
  localparam int LEAD_CYC = 4;
  localparam int LOCK_CYC = 3;
  localparam int REC_CYC  = 6;
  localparam int PU_PULSE = 2;
  localparam int GUARD    = (LOCK_CYC > REC_CYC) ? LOCK_CYC : REC_CYC;

  logic clk = 1'b0;
  logic rst, strb_in, is_dclk, self_drive;
  logic pull_dn, pull_up, pull_up_hiz;
  int   n_checks = 0;
  int   n_err    = 0;

  always #10 clk = ~clk;

  strobe_conditioner #(.LEAD_CYC(LEAD_CYC), .LOCK_CYC(LOCK_CYC),
                       .REC_CYC(REC_CYC), .PU_PULSE(PU_PULSE)) u0 (
    .clk(clk), .rst(rst), .strb_in(strb_in), .is_dclk(is_dclk),
    .self_drive(self_drive), .pull_dn(pull_dn), .pull_up(pull_up),
    .pull_up_hiz(pull_up_hiz)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_pad(input string tag, input int dn, input int up, input int hz);
    check({tag, " pull_dn"}, int'(pull_dn), dn);
    check({tag, " pull_up"}, int'(pull_up), up);
    check({tag, " pull_up_hiz"}, int'(pull_up_hiz), hz);
  endtask

  task automatic idle();
    strb_in = 1'b0; self_drive = 1'b0; is_dclk = 1'b0;
    step(16);
  endtask

  task automatic pulse_count(input logic dclk, input int w, output int cnt);
    cnt = 0;
    is_dclk = dclk;
    strb_in = 1'b1;
    for (int i = 0; i < w; i++) begin step(1); cnt += int'(pull_dn); end
    strb_in = 1'b0;
    for (int i = 0; i < 16; i++) begin step(1); cnt += int'(pull_dn); end
  endtask

  task automatic t_reset();
    check_pad("R8 reset", 0, 0, 1);
    strb_in = 1'b1;
    step(2);
    check("R8 no early rise", int'(pull_dn), 0);
    step(1);
    check("R8 guard expired, pass at edge 3", int'(pull_dn), 1);
    idle();
  endtask

  task automatic t_pass_release();
    is_dclk = 1'b0;
    strb_in = 1'b1;
    step(2);
    check("R1 before due", int'(pull_dn), 0);
    step(1);
    check("R1 rise at edge 3", int'(pull_dn), 1);
    step(4);
    check_pad("R6 asserted", 1, 0, 1);
    strb_in = 1'b0;
    step(2);
    check("R3 still high at edge 2", int'(pull_dn), 1);
    step(1);
    check_pad("R6 pulse start", 0, 1, 0);
    step(PU_PULSE - 1);
    check_pad("R6 pulse end", 0, 1, 0);
    step(1);
    check_pad("R6 released", 0, 0, 1);
    idle();
  endtask

  task automatic t_dclk_delay();
    is_dclk = 1'b1;
    strb_in = 1'b1;
    step(2 + LEAD_CYC);
    check("R2 held back", int'(pull_dn), 0);
    step(1);
    check("R2 rise after lead delay", int'(pull_dn), 1);
    step(3);
    strb_in = 1'b0;
    step(2);
    check("R3 dclk fall not yet", int'(pull_dn), 1);
    step(1);
    check("R3 dclk fall undelayed", int'(pull_dn), 0);
    idle();
  endtask

  task automatic t_widths();
    int c;
    pulse_count(1'b0, 1, c); check("R3 width 1 passes", c, 1); idle();
    pulse_count(1'b0, 4, c); check("R3 width 4 passes", c, 4); idle();
    pulse_count(1'b1, LEAD_CYC, c); check("R2 short dclk dropped", c, 0); idle();
    pulse_count(1'b1, LEAD_CYC + 1, c); check("R2 width lead+1", c, 1); idle();
    pulse_count(1'b1, 7, c); check("R3 dclk width shortened", c, 7 - LEAD_CYC); idle();
  endtask

  task automatic t_bounce();
    int gap = 0;
    is_dclk = 1'b0;
    strb_in = 1'b1;
    step(12);
    strb_in = 1'b0;
    step(1);
    strb_in = 1'b1;
    step(1);
    check("R4 fall not yet", int'(pull_dn), 1);
    for (int i = 0; i < 24; i++) begin
      step(1);
      if (pull_dn) break;
      gap++;
    end
    check("R4 R5 guard gap", gap, GUARD + 1);
    check("R5 held input forwarded", int'(pull_dn), 1);
    idle();
  endtask

  task automatic t_guard_drop();
    int c = 0;
    is_dclk = 1'b0;
    strb_in = 1'b1;
    step(12);
    strb_in = 1'b0;
    step(2);
    strb_in = 1'b1;
    step(3);
    strb_in = 1'b0;
    for (int i = 0; i < 16; i++) begin step(1); if (i >= 1) c += int'(pull_dn); end
    check("R5 dropped in guard not forwarded", c, 0);
    idle();
  endtask

  task automatic t_self_drive();
    int c = 0;
    is_dclk = 1'b0;
    self_drive = 1'b1;
    strb_in = 1'b1;
    for (int i = 0; i < 12; i++) begin step(1); c += int'(pull_dn); end
    check("R7 blocked while self driven", c, 0);
    self_drive = 1'b0;
    step(3);
    check("R7 passes once released", int'(pull_dn), 1);
    step(2);
    self_drive = 1'b1;
    step(2);
    check("R7 drop not yet", int'(pull_dn), 1);
    step(1);
    check("R7 self drive releases line", int'(pull_dn), 0);
    idle();
  endtask

  initial begin
    rst = 1'b1; strb_in = 1'b0; is_dclk = 1'b0; self_drive = 1'b0;
    step(4);
    rst = 1'b0;
    step(1);
    t_reset();
    t_pass_release();
    t_dclk_delay();
    t_widths();
    t_bounce();
    t_guard_drop();
    t_self_drive();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule